// File: doc/BRIEF.md
# Multicycle Datapath Control Sequencer

This block is the hardwired controller that steps a shared-resource processor datapath through its instruction phases. One memory, one ALU and one register file serve every phase, so each instruction is split into three to five clock cycles. The controller tells the datapath in each cycle which unit works, which operands it takes and which register captures the result. It is a Moore machine with twelve states. Every control output is decoded from the state register alone. The 6-bit opcode and the ALU overflow flag only choose the next state.

After the shared fetch and decode cycles, the controller branches on the opcode into one of five paths: memory reference, register-to-register, conditional branch, jump, or undefined-opcode trap. An overflow seen at the end of the register-to-register completion cycle sends it to a second trap state. Each trap state saves the faulting instruction's address, records a cause bit and redirects the program counter to a fixed handler vector. All paths return to fetch.

Top module: `mc_ctrl_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the state returns to fetch. In fetch, `mem_rd`, `ir_we` and `pc_we` are 1, `alu_b_sel`=01, and every other output is 0.
- R2: In decode, `alu_b_sel`=11 and all other outputs are 0. The next state comes from the opcode: 100011 (load) or 101011 (store) go to address calculation, 000000 to register execute, 000100 to branch, 000010 to jump, and any other value to the undefined-opcode trap.
- R3: A load takes 5 cycles: fetch, decode, address calculation (`alu_a_sel`=1, `alu_b_sel`=10), memory read (`mem_rd`=1, `addr_sel`=1), and register write-back (`rf_we`=1, `rf_data_sel`=1, `rf_dst_sel`=0).
- R4: A store takes 4 cycles: fetch, decode, address calculation, and memory write (`mem_wr`=1, `addr_sel`=1).
- R5: A register-to-register instruction takes 4 cycles: fetch, decode, execute (`alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=10), and completion (`rf_we`=1, `rf_dst_sel`=1, `rf_data_sel`=0).
- R6: `ovf` is sampled only at the end of the register completion cycle. If it is 1 there, the next state is the overflow trap. In every other state, `ovf` has no effect on the sequence.
- R7: A branch takes 3 cycles. Its third cycle drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01, `pc_we_cond`=1 and `pc_src`=01.
- R8: A jump takes 3 cycles. Its third cycle drives `pc_we`=1 and `pc_src`=10.
- R9: Both trap states drive `cause_we`, `epc_we` and `pc_we` to 1, with `alu_b_sel`=01, `alu_op`=01 and `pc_src`=11. `cause_code` is 0 for the undefined-opcode trap and 1 for the overflow trap. Each trap lasts one cycle and is followed by fetch.
- R10: Outputs are Moore outputs. They change only at a rising clock edge and do not respond to `opcode` or `ovf` within a cycle.
- R11: In each state, every output not named for that state is 0. In particular, `mem_rd` and `mem_wr` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| ovf | input | 1 | ALU overflow flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address select: 0 = PC, 1 = ALU result register |
| ir_we | output | 1 | Instruction register load |
| pc_we | output | 1 | Unconditional PC load |
| pc_we_cond | output | 1 | PC load gated by the ALU zero flag |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target, 11 trap vector |
| alu_op | output | 2 | ALU function: 00 add, 01 subtract, 10 from function field |
| alu_a_sel | output | 1 | ALU A operand: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 extended immediate, 11 shifted immediate |
| rf_we | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination field: 0 = rt, 1 = rd |
| rf_data_sel | output | 1 | Write data: 0 = ALU result register, 1 = memory data register |
| epc_we | output | 1 | Exception PC register load |
| cause_we | output | 1 | Cause register load |
| cause_code | output | 1 | Cause bit: 0 undefined opcode, 1 overflow |

## Verification
Each of the five legal opcodes is run to completion. The observed output sequence tells the dispatch targets apart and, through the length of each path, the 3, 4 and 5 cycle instruction classes. Two opcodes outside the legal set confirm that an unknown encoding falls to the undefined-opcode trap rather than to any legal path. Overflow is asserted in three patterns: only in the register completion cycle, which must trap with cause 1; in every cycle of a load, which must not trap; and in every other cycle of a register instruction, which must not trap. These patterns separate correct sampling from early or stray sampling. In every cycle, `opcode` and `ovf` are also perturbed between edges, and a reset is issued in the middle of a store. Together these show the outputs are purely state-driven and that reset wins over any path.

// File: rtl/mc_ctrl_seq_pkg.sv
// Shared definitions for the multicycle control sequencer.
// Assumes a 6-bit opcode field and at most 16 states in a 4-bit register.
package mc_ctrl_seq_pkg;

    localparam int STATE_W = 4;

    // Sequencer states; the numeric values are internal to the block.
    typedef enum logic [STATE_W-1:0] {
        ST_FETCH    = 4'd0,
        ST_DECODE   = 4'd1,
        ST_MEM_ADDR = 4'd2,
        ST_MEM_RD   = 4'd3,
        ST_LOAD_WB  = 4'd4,
        ST_MEM_WR   = 4'd5,
        ST_REG_EXE  = 4'd6,
        ST_REG_WB   = 4'd7,
        ST_BRANCH   = 4'd8,
        ST_JUMP     = 4'd9,
        ST_TRAP_UND = 4'd10,
        ST_TRAP_OVF = 4'd11
    } ctl_state_e;

    // PC source encodings
    localparam logic [1:0] PCS_ALU  = 2'b00;
    localparam logic [1:0] PCS_AREG = 2'b01;
    localparam logic [1:0] PCS_JMP  = 2'b10;
    localparam logic [1:0] PCS_VEC  = 2'b11;

    // ALU function encodings
    localparam logic [1:0] AOP_ADD  = 2'b00;
    localparam logic [1:0] AOP_SUB  = 2'b01;
    localparam logic [1:0] AOP_FUNC = 2'b10;

    // ALU B operand encodings
    localparam logic [1:0] BSEL_REG  = 2'b00;
    localparam logic [1:0] BSEL_FOUR = 2'b01;
    localparam logic [1:0] BSEL_IMM  = 2'b10;
    localparam logic [1:0] BSEL_SHL  = 2'b11;

    // Bundle of every datapath control line driven in one state.
    typedef struct packed {
        logic       mem_rd;
        logic       mem_wr;
        logic       addr_sel;
        logic       ir_we;
        logic       pc_we;
        logic       pc_we_cond;
        logic [1:0] pc_src;
        logic [1:0] alu_op;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic       rf_we;
        logic       rf_dst_sel;
        logic       rf_data_sel;
        logic       epc_we;
        logic       cause_we;
        logic       cause_code;
    } ctl_word_t;

    localparam ctl_word_t CTL_IDLE = '0;

endpackage

// File: rtl/mc_ctrl_seq_state_reg.sv
// State register of the sequencer.
// Synchronous active-low reset forces the fetch state; otherwise it loads
// the next state every cycle.
module mc_ctrl_seq_state_reg
    import mc_ctrl_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ctl_state_e nxt,
    output ctl_state_e cur
);

    // Register the next state, reset to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= ST_FETCH;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/mc_ctrl_seq_next.sv
// Next-state function of the sequencer.
// Branches on the opcode after decode, on load/store after address
// calculation, and on the overflow flag after register completion.
// Unused state codes fall back to fetch.
module mc_ctrl_seq_next
    import mc_ctrl_seq_pkg::*;
#(
    parameter int               OPC_W     = 6,
    parameter logic [OPC_W-1:0] OPC_REG   = 6'b000000,
    parameter logic [OPC_W-1:0] OPC_LOAD  = 6'b100011,
    parameter logic [OPC_W-1:0] OPC_STORE = 6'b101011,
    parameter logic [OPC_W-1:0] OPC_BEQ   = 6'b000100,
    parameter logic [OPC_W-1:0] OPC_JUMP  = 6'b000010
) (
    input  ctl_state_e       cur,
    input  logic [OPC_W-1:0] opcode,
    input  logic             ovf,
    output ctl_state_e       nxt
);

    logic is_mem;
    logic is_load;

    // Opcode class flags used by the two dispatch points.
    always_comb begin
        is_mem  = (opcode == OPC_LOAD) || (opcode == OPC_STORE);
        is_load = (opcode == OPC_LOAD);
    end

    // Select the successor of the current state.
    always_comb begin
        nxt = ST_FETCH;
        case (cur)
            ST_FETCH: nxt = ST_DECODE;
            ST_DECODE: begin
                if (is_mem)                  nxt = ST_MEM_ADDR;
                else if (opcode == OPC_REG)  nxt = ST_REG_EXE;
                else if (opcode == OPC_BEQ)  nxt = ST_BRANCH;
                else if (opcode == OPC_JUMP) nxt = ST_JUMP;
                else                         nxt = ST_TRAP_UND;
            end
            ST_MEM_ADDR: nxt = is_load ? ST_MEM_RD : ST_MEM_WR;
            ST_MEM_RD:   nxt = ST_LOAD_WB;
            ST_REG_EXE:  nxt = ST_REG_WB;
            ST_REG_WB:   nxt = ovf ? ST_TRAP_OVF : ST_FETCH;
            default:     nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_seq_decode.sv
// Moore output decoder of the sequencer.
// Maps the current state to the full control word.
// Any line not set for a state stays at zero.
module mc_ctrl_seq_decode
    import mc_ctrl_seq_pkg::*;
(
    input  ctl_state_e cur,
    output ctl_word_t  word
);

    // Build the control word for the current state.
    always_comb begin
        word = CTL_IDLE;
        case (cur)
            ST_FETCH: begin
                word.mem_rd    = 1'b1;
                word.ir_we     = 1'b1;
                word.pc_we     = 1'b1;
                word.alu_b_sel = BSEL_FOUR;
                word.alu_op    = AOP_ADD;
                word.pc_src    = PCS_ALU;
            end
            ST_DECODE: begin
                word.alu_b_sel = BSEL_SHL;
                word.alu_op    = AOP_ADD;
            end
            ST_MEM_ADDR: begin
                word.alu_a_sel = 1'b1;
                word.alu_b_sel = BSEL_IMM;
                word.alu_op    = AOP_ADD;
            end
            ST_MEM_RD: begin
                word.mem_rd   = 1'b1;
                word.addr_sel = 1'b1;
            end
            ST_LOAD_WB: begin
                word.rf_we       = 1'b1;
                word.rf_data_sel = 1'b1;
                word.rf_dst_sel  = 1'b0;
            end
            ST_MEM_WR: begin
                word.mem_wr   = 1'b1;
                word.addr_sel = 1'b1;
            end
            ST_REG_EXE: begin
                word.alu_a_sel = 1'b1;
                word.alu_b_sel = BSEL_REG;
                word.alu_op    = AOP_FUNC;
            end
            ST_REG_WB: begin
                word.rf_we       = 1'b1;
                word.rf_dst_sel  = 1'b1;
                word.rf_data_sel = 1'b0;
            end
            ST_BRANCH: begin
                word.alu_a_sel  = 1'b1;
                word.alu_b_sel  = BSEL_REG;
                word.alu_op     = AOP_SUB;
                word.pc_we_cond = 1'b1;
                word.pc_src     = PCS_AREG;
            end
            ST_JUMP: begin
                word.pc_we  = 1'b1;
                word.pc_src = PCS_JMP;
            end
            ST_TRAP_UND, ST_TRAP_OVF: begin
                word.cause_we   = 1'b1;
                word.epc_we     = 1'b1;
                word.pc_we      = 1'b1;
                word.alu_b_sel  = BSEL_FOUR;
                word.alu_op     = AOP_SUB;
                word.pc_src     = PCS_VEC;
                word.cause_code = (cur == ST_TRAP_OVF);
            end
            default: word = CTL_IDLE;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_seq.sv
// Top of the multicycle control sequencer.
// A twelve-state Moore machine that drives every datapath control line from
// its state register. Opcode and overflow only steer state transitions.
// Assumes the opcode stays stable from decode to the end of the instruction.
module mc_ctrl_seq
    import mc_ctrl_seq_pkg::*;
#(
    parameter int               OPC_W     = 6,
    parameter logic [OPC_W-1:0] OPC_REG   = 6'b000000,
    parameter logic [OPC_W-1:0] OPC_LOAD  = 6'b100011,
    parameter logic [OPC_W-1:0] OPC_STORE = 6'b101011,
    parameter logic [OPC_W-1:0] OPC_BEQ   = 6'b000100,
    parameter logic [OPC_W-1:0] OPC_JUMP  = 6'b000010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             ovf,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             addr_sel,
    output logic             ir_we,
    output logic             pc_we,
    output logic             pc_we_cond,
    output logic [1:0]       pc_src,
    output logic [1:0]       alu_op,
    output logic             alu_a_sel,
    output logic [1:0]       alu_b_sel,
    output logic             rf_we,
    output logic             rf_dst_sel,
    output logic             rf_data_sel,
    output logic             epc_we,
    output logic             cause_we,
    output logic             cause_code
);

    ctl_state_e state_q;
    ctl_state_e state_d;
    ctl_word_t  ctl;

    mc_ctrl_seq_state_reg u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (state_d),
        .cur   (state_q)
    );

    mc_ctrl_seq_next #(
        .OPC_W     (OPC_W),
        .OPC_REG   (OPC_REG),
        .OPC_LOAD  (OPC_LOAD),
        .OPC_STORE (OPC_STORE),
        .OPC_BEQ   (OPC_BEQ),
        .OPC_JUMP  (OPC_JUMP)
    ) u_next (
        .cur    (state_q),
        .opcode (opcode),
        .ovf    (ovf),
        .nxt    (state_d)
    );

    mc_ctrl_seq_decode u_dec (
        .cur  (state_q),
        .word (ctl)
    );

    // Spread the control word onto the output ports.
    always_comb begin
        mem_rd      = ctl.mem_rd;
        mem_wr      = ctl.mem_wr;
        addr_sel    = ctl.addr_sel;
        ir_we       = ctl.ir_we;
        pc_we       = ctl.pc_we;
        pc_we_cond  = ctl.pc_we_cond;
        pc_src      = ctl.pc_src;
        alu_op      = ctl.alu_op;
        alu_a_sel   = ctl.alu_a_sel;
        alu_b_sel   = ctl.alu_b_sel;
        rf_we       = ctl.rf_we;
        rf_dst_sel  = ctl.rf_dst_sel;
        rf_data_sel = ctl.rf_data_sel;
        epc_we      = ctl.epc_we;
        cause_we    = ctl.cause_we;
        cause_code  = ctl.cause_code;
    end

endmodule

// File: rtl/mc_ctrl_seq_chk.sv
// Property checker for the multicycle control sequencer.
// It observes the ports plus the state register and is bound into every
// instance of the top.
module mc_ctrl_seq_chk
    import mc_ctrl_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] opcode,
    input logic       ovf,
    input ctl_state_e state,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       ir_we,
    input logic       pc_we,
    input logic       pc_we_cond,
    input logic [1:0] pc_src,
    input logic       rf_we,
    input logic       epc_we,
    input logic       cause_we,
    input logic       cause_code
);

    logic [10:0] obs;

    // Collect the observed outputs for the stability check.
    always_comb begin
        obs = {mem_rd, mem_wr, ir_we, pc_we, pc_we_cond, pc_src,
               rf_we, epc_we, cause_we, cause_code};
    end

    a_r1_reset_to_fetch: assert property (@(posedge clk)
        !rst_n |=> (state == ST_FETCH && ir_we && mem_rd));

    a_r2_load_store_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && (opcode == 6'b100011 || opcode == 6'b101011))
        |=> state == ST_MEM_ADDR);

    a_r2_unknown_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && opcode != 6'b100011 && opcode != 6'b101011 &&
         opcode != 6'b000000 && opcode != 6'b000100 && opcode != 6'b000010)
        |=> (state == ST_TRAP_UND && cause_code == 1'b0));

    a_r3_load_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEM_RD) |=> (rf_we && !mem_rd));

    a_r6_overflow_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REG_WB && ovf) |=> (cause_we && cause_code));

    a_r6_no_stray_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_REG_WB) |=> (state != ST_TRAP_OVF));

    a_r7_branch_returns: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we_cond |=> (state == ST_FETCH));

    a_r9_trap_returns: assert property (@(posedge clk) disable iff (!rst_n)
        cause_we |=> (state == ST_FETCH && !cause_we));

    a_r10_moore_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(state) |-> $stable(obs));

    a_r11_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

bind mc_ctrl_seq mc_ctrl_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opcode     (opcode),
    .ovf        (ovf),
    .state      (state_q),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .ir_we      (ir_we),
    .pc_we      (pc_we),
    .pc_we_cond (pc_we_cond),
    .pc_src     (pc_src),
    .rf_we      (rf_we),
    .epc_we     (epc_we),
    .cause_we   (cause_we),
    .cause_code (cause_code)
);

// File: tb/sim_mc_ctrl_seq.sv
`timescale 1ns/1ps
// Scoreboard bench for the multicycle control sequencer.
// The driver pushes the expected control word for every cycle. The monitor
// pops and compares one word per cycle, shortly after the falling edge.
module sim_mc_ctrl_seq;

    localparam logic [5:0] OP_R   = 6'b000000;
    localparam logic [5:0] OP_LW  = 6'b100011;
    localparam logic [5:0] OP_SW  = 6'b101011;
    localparam logic [5:0] OP_BEQ = 6'b000100;
    localparam logic [5:0] OP_J   = 6'b000010;

    typedef struct {
        logic [18:0] v;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] opcode = 6'd0;
    logic ovf = 1'b0;

    logic mem_rd, mem_wr, addr_sel, ir_we, pc_we, pc_we_cond;
    logic [1:0] pc_src, alu_op, alu_b_sel;
    logic alu_a_sel, rf_we, rf_dst_sel, rf_data_sel, epc_we, cause_we, cause_code;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    mc_ctrl_seq u0 (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .ovf(ovf),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_we(ir_we),
        .pc_we(pc_we), .pc_we_cond(pc_we_cond), .pc_src(pc_src), .alu_op(alu_op),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .rf_we(rf_we),
        .rf_dst_sel(rf_dst_sel), .rf_data_sel(rf_data_sel), .epc_we(epc_we),
        .cause_we(cause_we), .cause_code(cause_code)
    );

    function automatic logic [18:0] actual();
        return {mem_rd, mem_wr, addr_sel, ir_we, pc_we, pc_we_cond, pc_src,
                alu_op, alu_a_sel, alu_b_sel, rf_we, rf_dst_sel, rf_data_sel,
                epc_we, cause_we, cause_code};
    endfunction

    // Expected control word for each phase index, taken from the requirements.
    function automatic logic [18:0] expect_word(input int ph);
        logic rd = 0, wr = 0, as = 0, ir = 0, pw = 0, pwc = 0;
        logic [1:0] ps = 0, op = 0, bs = 0;
        logic a = 0, rw = 0, dst = 0, dat = 0, ep = 0, cw = 0, cc = 0;
        case (ph)
            0:  begin rd = 1; ir = 1; pw = 1; bs = 2'b01; end
            1:  begin bs = 2'b11; end
            2:  begin a = 1; bs = 2'b10; end
            3:  begin rd = 1; as = 1; end
            4:  begin rw = 1; dat = 1; end
            5:  begin wr = 1; as = 1; end
            6:  begin a = 1; op = 2'b10; end
            7:  begin rw = 1; dst = 1; end
            8:  begin a = 1; op = 2'b01; pwc = 1; ps = 2'b01; end
            9:  begin pw = 1; ps = 2'b10; end
            10, 11: begin cw = 1; ep = 1; pw = 1; bs = 2'b01; op = 2'b01;
                          ps = 2'b11; cc = (ph == 11); end
            default: ;
        endcase
        return {rd, wr, as, ir, pw, pwc, ps, op, a, bs, rw, dst, dat, ep, cw, cc};
    endfunction

    // One cycle: drive inputs and queue the expected word. Then perturb the
    // inputs between edges and confirm the outputs hold (R10).
    task automatic step(input logic [5:0] op, input logic ov, input int ph,
                        input string tag);
        logic [18:0] e;
        @(negedge clk);
        rst_n  = 1'b1;
        opcode = op;
        ovf    = ov;
        e = expect_word(ph);
        q.push_back('{v: e, tag: tag});
        #1.5;
        opcode = ~op;
        ovf    = ~ov;
        #0.4;
        total++;
        if (actual() !== e) begin
            bad++;
            $display("FAIL R10 phase %0d: actual=%h expected=%h", ph, actual(), e);
        end
        opcode = op;
        ovf    = ov;
    endtask

    // Run one instruction. ov_rest drives ovf outside the register completion
    // cycle and ov_wb drives it inside. The run stops after 'limit' cycles.
    task automatic run_instr(input logic [5:0] op, input logic ov_rest,
                             input logic ov_wb, input int limit, input string tag);
        int seq[$];
        seq = '{0, 1};
        if (op == OP_LW)       seq = '{0, 1, 2, 3, 4};
        else if (op == OP_SW)  seq = '{0, 1, 2, 5};
        else if (op == OP_R)   seq = ov_wb ? '{0, 1, 6, 7, 11} : '{0, 1, 6, 7};
        else if (op == OP_BEQ) seq = '{0, 1, 8};
        else if (op == OP_J)   seq = '{0, 1, 9};
        else                   seq = '{0, 1, 10};
        foreach (seq[i]) begin
            if (i < limit)
                step(op, (seq[i] == 7) ? ov_wb : ov_rest, seq[i], tag);
        end
    endtask

    // Hold reset across one edge, then check the fetch word (R1).
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        q.push_back('{v: expect_word(0), tag: "R1 reset"});
    endtask

    // Monitor: compare one queued word per cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                total++;
                if (actual() !== it.v) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, actual(), it.v);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        do_reset();
        run_instr(OP_LW,  1'b0, 1'b0, 9, "R3 load");
        run_instr(OP_SW,  1'b0, 1'b0, 9, "R4 store");
        run_instr(OP_R,   1'b0, 1'b0, 9, "R5 reg");
        run_instr(OP_R,   1'b0, 1'b1, 9, "R6/R9 overflow trap");
        run_instr(OP_LW,  1'b1, 1'b1, 9, "R6 ovf ignored in load");
        run_instr(OP_R,   1'b1, 1'b0, 9, "R6 ovf ignored outside completion");
        run_instr(OP_BEQ, 1'b0, 1'b0, 9, "R7 branch");
        run_instr(OP_J,   1'b0, 1'b0, 9, "R8 jump");
        run_instr(6'b111111, 1'b0, 1'b0, 9, "R2/R9 undefined 111111");
        run_instr(6'b000001, 1'b1, 1'b0, 9, "R2/R9 undefined 000001");
        run_instr(OP_SW,  1'b0, 1'b0, 3, "R11 store partial");
        do_reset();
        run_instr(OP_BEQ, 1'b0, 1'b0, 9, "R1 after mid reset");
        run_instr(OP_LW,  1'b0, 1'b0, 9, "R11 load again");
        repeat (3) @(negedge clk);
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R10 queue drain: actual=%0d expected=0", q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule